// File: doc/BRIEF.md
# Multiplexed Bus Peripheral Interface

This block is the bus front end of a peripheral that sits on a shared address/data bus. The falling edge of the address latch strobe captures three things: the 8-bit address present on the bus, the level of the chip-enable pin and the memory/I-O space select. After that edge, a low read or write strobe performs one cycle against the captured target. In memory space the target is a 256-entry by 8-bit static RAM. In I/O space it is one of a small set of registers that are decoded from the three lowest address bits.

The block owns the write-only command register. Its content is passed on to the port and timer logic through `cmd_o`. A read of I/O address 000 returns the status byte that the neighbouring logic supplies. All other I/O reads return the port and timer values that the neighbours present. Every I/O access that is decoded produces a one-cycle strobe for the selected register. A status read therefore also produces a pulse, which the timer logic can use to clear its flag. The bus is split into an input, an output and an output enable, so a tri-state buffer at the pad ring can be driven from it. All control inputs are sampled on the block clock, and their edges are found by comparing each input with its value in the previous cycle.

Top module: `mbus_periph`

## Requirements
- R1: On the clock after `ale` falls, the block holds `ad_i`, the chip-enable level and `io_sel` as the cycle target. Later changes of those pins do not alter the target until the next falling edge of `ale`.
- R2: The parameter `CE_ACT_HIGH` sets the enabled level of `chip_en`: 0 means active low and 1 means active high. When the captured enable is inactive, the block does not drive the bus, does not write anything and gives no strobe.
- R3: A captured `io_sel` of 0 selects the RAM. A write stores `ad_i` at the captured address, a read returns the stored byte, every one of the 256 addresses holds its own value, and no I/O strobe is given.
- R4: A captured `io_sel` of 1 selects a register by address bits [2:0] alone. The codes are 000 command/status, 001 port A, 010 port B, 011 port C, 100 timer low byte and 101 timer high byte. Bits [7:3] are ignored.
- R5: A write to I/O code 000 loads `cmd_o` from `ad_i`. A read of code 000 returns `status_i` and never the command value, and `cmd_o` changes only through such a write.
- R6: Reset clears `cmd_o` to 0, so all three ports are in input mode. Reset also clears both strobe vectors and the captured enable, which releases the bus.
- R7: `ad_oe` is 1 only while `rd_n` is 0 and the captured enable is active. It is 0 at all other times.
- R8: One clock after an enabled I/O falling edge of `rd_n` or `wr_n`, exactly one bit of `io_rd_stb_o` or `io_wr_stb_o` is 1 for one cycle. The bit index equals the register code. A write also places the written byte on `io_wdata_o`.
- R9: I/O codes 110 and 111 are unused. A read of either returns 0x00, a write to either gives no strobe, and such a write leaves `cmd_o` unchanged.
- R10: A read of port C returns {2'b00, `pc_i`}. Reads of port A, port B, timer low byte and timer high byte return `pa_i`, `pb_i`, `tmr_lo_i` and `tmr_hi_i` as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ale | input | 1 | Address latch strobe; its falling edge captures the target |
| chip_en | input | 1 | Chip enable; polarity set by CE_ACT_HIGH |
| io_sel | input | 1 | 0 selects memory space, 1 selects I/O space |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ad_i | input | 8 | Address/data from the shared bus |
| ad_o | output | 8 | Read data toward the shared bus |
| ad_oe | output | 1 | Bus output enable |
| status_i | input | 8 | Status byte from the port and timer logic |
| pa_i | input | 8 | Port A read value |
| pb_i | input | 8 | Port B read value |
| pc_i | input | 6 | Port C read value |
| tmr_lo_i | input | 8 | Timer low byte read value |
| tmr_hi_i | input | 8 | Timer high byte read value |
| cmd_o | output | 8 | Command register content |
| io_wdata_o | output | 8 | Byte of the most recent I/O write |
| io_rd_stb_o | output | 6 | One-cycle read strobe per register code |
| io_wr_stb_o | output | 6 | One-cycle write strobe per register code |

## Verification
The register decode is exercised with a table of I/O reads. Each of the six register codes, both unused codes, and addresses whose upper five bits are set are read with distinct values on every source. A wrong decode, a dropped upper-bit mask or a swapped source therefore each show up as a distinct wrong byte or strobe index. RAM writes followed by reads over all 256 addresses use an address-dependent pattern, which separates aliasing from storage faults. After every capture, the bench moves the enable, select and bus pins to opposite values. This separates latched behaviour from live-pin behaviour. A second instance with the opposite enable polarity shows that a cycle disabled on one variant is carried out by the other.

// File: rtl/mbus_periph.sv
module mbus_periph #(
  parameter bit CE_ACT_HIGH = 1'b0,
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PCW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ale,
  input  logic           chip_en,
  input  logic           io_sel,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [DW-1:0]  ad_i,
  output logic [DW-1:0]  ad_o,
  output logic           ad_oe,
  input  logic [DW-1:0]  status_i,
  input  logic [DW-1:0]  pa_i,
  input  logic [DW-1:0]  pb_i,
  input  logic [PCW-1:0] pc_i,
  input  logic [DW-1:0]  tmr_lo_i,
  input  logic [DW-1:0]  tmr_hi_i,
  output logic [DW-1:0]  cmd_o,
  output logic [DW-1:0]  io_wdata_o,
  output logic [5:0]     io_rd_stb_o,
  output logic [5:0]     io_wr_stb_o
);
  localparam int DEPTH = 1 << AW;
  localparam int NREG  = 6;

  logic [DW-1:0] mem [DEPTH];
  logic          ale_q, rd_q, wr_q;
  logic [AW-1:0] addr_l;
  logic          en_l, io_l;
  logic [2:0]    sel;
  logic [NREG-1:0] dec;
  logic          ale_fall, rd_fall, wr_fall, io_rd, io_wr, mem_wr;
  logic [DW-1:0] reg_rdata;

  assign ale_fall = ale_q & ~ale;
  assign rd_fall  = rd_q & ~rd_n;
  assign wr_fall  = wr_q & ~wr_n;
  assign sel      = addr_l[2:0];
  assign dec      = (sel < 3'(NREG)) ? (NREG'(1) << sel) : '0;
  assign io_rd    = en_l & io_l & rd_fall;
  assign io_wr    = en_l & io_l & wr_fall;
  assign mem_wr   = en_l & ~io_l & wr_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q  <= 1'b0;
      rd_q   <= 1'b1;
      wr_q   <= 1'b1;
      addr_l <= '0;
      en_l   <= 1'b0;
      io_l   <= 1'b0;
    end else begin
      ale_q <= ale;
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      if (ale_fall) begin
        addr_l <= ad_i[AW-1:0];
        en_l   <= (chip_en == CE_ACT_HIGH);
        io_l   <= io_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_o       <= '0;
      io_wdata_o  <= '0;
      io_rd_stb_o <= '0;
      io_wr_stb_o <= '0;
    end else begin
      io_rd_stb_o <= io_rd ? dec : '0;
      io_wr_stb_o <= io_wr ? dec : '0;
      if (io_wr) io_wdata_o <= ad_i;
      if (io_wr && dec[0]) cmd_o <= ad_i;
    end
  end

  always_ff @(posedge clk)
    if (mem_wr) mem[addr_l] <= ad_i;

  always_comb begin
    case (sel)
      3'd0:    reg_rdata = status_i;
      3'd1:    reg_rdata = pa_i;
      3'd2:    reg_rdata = pb_i;
      3'd3:    reg_rdata = {{(DW-PCW){1'b0}}, pc_i};
      3'd4:    reg_rdata = tmr_lo_i;
      3'd5:    reg_rdata = tmr_hi_i;
      default: reg_rdata = '0;
    endcase
  end

  assign ad_oe = en_l & ~rd_n;
  assign ad_o  = io_l ? reg_rdata : mem[addr_l];
endmodule

// File: rtl/mbus_periph_chk.sv
module mbus_periph_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       ad_oe,
  input logic [5:0] io_rd_stb_o,
  input logic [5:0] io_wr_stb_o,
  input logic [7:0] cmd_o
);
  a_r7_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> !ad_oe);
  a_r8_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(io_rd_stb_o));
  a_r8_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(io_wr_stb_o));
  a_r8_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_stb_o != 6'd0) |=> (io_rd_stb_o == 6'd0));
  a_r8_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr_stb_o != 6'd0) |=> (io_wr_stb_o == 6'd0));
  a_r8_wr_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr_stb_o != 6'd0) |-> $past(!wr_n));
  a_r5_cmd_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_o) |-> io_wr_stb_o[0]);
endmodule

bind mbus_periph mbus_periph_chk u_chk (.*);

// File: tb/mbus_periph_bench.sv
module mbus_periph_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, ale = 1'b0, chip_en = 1'b1, io_sel = 1'b0;
  logic rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ad_i = 8'h00;
  logic [7:0] status_i = 8'h5A, pa_i = 8'h11, pb_i = 8'h22;
  logic [7:0] tmr_lo_i = 8'h44, tmr_hi_i = 8'h83;
  logic [5:0] pc_i = 6'h3C;
  logic [7:0] ad_o, cmd_o, io_wdata_o, ad_o_hi, cmd_o_hi, wd_hi;
  logic       ad_oe, ad_oe_hi;
  logic [5:0] rs, ws, rs_hi, ws_hi;

  mbus_periph u_mbus_periph (
    .clk, .rst_n, .ale, .chip_en, .io_sel, .rd_n, .wr_n, .ad_i,
    .ad_o, .ad_oe, .status_i, .pa_i, .pb_i, .pc_i, .tmr_lo_i, .tmr_hi_i,
    .cmd_o, .io_wdata_o, .io_rd_stb_o(rs), .io_wr_stb_o(ws));

  mbus_periph #(.CE_ACT_HIGH(1'b1)) u_mbus_periph_hi (
    .clk, .rst_n, .ale, .chip_en, .io_sel, .rd_n, .wr_n, .ad_i,
    .ad_o(ad_o_hi), .ad_oe(ad_oe_hi), .status_i, .pa_i, .pb_i, .pc_i,
    .tmr_lo_i, .tmr_hi_i, .cmd_o(cmd_o_hi), .io_wdata_o(wd_hi),
    .io_rd_stb_o(rs_hi), .io_wr_stb_o(ws_hi));

  int n_chk = 0, n_fail = 0;

  localparam logic [15:0] VEC [10] = '{
    16'h005A, 16'h0111, 16'hF911, 16'h0222, 16'h033C,
    16'h0444, 16'h0583, 16'h0600, 16'hFF00, 16'h7D83};

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_stb(input logic [7:0] a);
    return (a[2:0] < 3'd6) ? (6'd1 << a[2:0]) : 6'd0;
  endfunction

  task automatic latch(input logic io, input logic [7:0] a, input logic ce);
    @(negedge clk); ale = 1'b1; ad_i = a; io_sel = io; chip_en = ce;
    @(negedge clk); ale = 1'b0;
    @(negedge clk); ad_i = 8'hEE; io_sel = ~io; chip_en = ~ce;
  endtask

  task automatic rd(output logic [7:0] d, output logic oe, output logic [5:0] s1,
                    output logic [5:0] s2, output logic [7:0] d_hi, output logic oe_hi);
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk); d = ad_o; oe = ad_oe; s1 = rs; d_hi = ad_o_hi; oe_hi = ad_oe_hi;
    @(negedge clk); s2 = rs; rd_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d, output logic [5:0] s1, output logic [7:0] wd,
                    output logic [5:0] s2);
    @(negedge clk); wr_n = 1'b0; ad_i = d;
    @(negedge clk); s1 = ws; wd = io_wdata_o;
    @(negedge clk); s2 = ws; wr_n = 1'b1;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d, wd, dh;
    logic oe, oeh;
    logic [5:0] s1, s2;
    repeat (3) @(negedge clk);
    chk("R6 cmd after reset", {8'h0, cmd_o}, 16'h0);
    chk("R6 bus released in reset", {15'h0, ad_oe}, 16'h0);
    chk("R6 strobes cleared", {4'h0, rs, ws}, 16'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      latch(1'b1, VEC[i][15:8], 1'b0);
      rd(d, oe, s1, s2, dh, oeh);
      chk($sformatf("R4 R10 R9 R5 read data addr %h", VEC[i][15:8]), {8'h0, d}, {8'h0, VEC[i][7:0]});
      chk("R7 bus driven during read", {15'h0, oe}, 16'h1);
      chk($sformatf("R8 read strobe addr %h", VEC[i][15:8]), {10'h0, s1}, {10'h0, exp_stb(VEC[i][15:8])});
      chk("R8 read strobe one cycle", {10'h0, s2}, 16'h0);
    end
    @(negedge clk);
    chk("R7 bus released after read", {15'h0, ad_oe}, 16'h0);

    latch(1'b1, 8'hF8, 1'b0);
    wr(8'hA5, s1, wd, s2);
    chk("R5 command write strobe", {10'h0, s1}, 16'h0001);
    chk("R8 write data out", {8'h0, wd}, 16'h00A5);
    chk("R8 write strobe one cycle", {10'h0, s2}, 16'h0);
    chk("R5 command loaded", {8'h0, cmd_o}, 16'h00A5);
    latch(1'b1, 8'h00, 1'b0);
    rd(d, oe, s1, s2, dh, oeh);
    chk("R5 status not command", {8'h0, d}, 16'h005A);

    for (int a = 1; a < 8; a++) begin
      latch(1'b1, 8'(a) | 8'hA0, 1'b0);
      wr(8'h30 + 8'(a), s1, wd, s2);
      chk($sformatf("R4 R9 write strobe code %0d", a), {10'h0, s1}, {10'h0, exp_stb(8'(a))});
      if (a < 6) chk("R8 write data", {8'h0, wd}, {8'h0, 8'h30 + 8'(a)});
      chk("R9 R5 command untouched", {8'h0, cmd_o}, 16'h00A5);
    end

    for (int a = 0; a < 256; a++) begin
      latch(1'b0, 8'(a), 1'b0);
      wr(8'(a) ^ 8'h5C, s1, wd, s2);
      if (a == 0) chk("R3 memory write gives no strobe", {10'h0, s1}, 16'h0);
    end
    for (int a = 0; a < 256; a++) begin
      latch(1'b0, 8'(a), 1'b0);
      rd(d, oe, s1, s2, dh, oeh);
      chk($sformatf("R3 RAM readback %h", a), {7'h0, oe, d}, {8'h1, 8'(a) ^ 8'h5C});
      if (a == 0) chk("R3 memory read gives no strobe", {10'h0, s1}, 16'h0);
    end

    latch(1'b0, 8'h10, 1'b1);
    wr(8'hFF, s1, wd, s2);
    rd(d, oe, s1, s2, dh, oeh);
    chk("R2 disabled low variant does not drive", {15'h0, oe}, 16'h0);
    chk("R2 high variant enabled drives FF", {7'h0, oeh, dh}, 16'h01FF);
    latch(1'b0, 8'h10, 1'b0);
    rd(d, oe, s1, s2, dh, oeh);
    chk("R2 disabled write ignored", {7'h0, oe, d}, {8'h1, 8'h10 ^ 8'h5C});
    chk("R2 high variant disabled", {15'h0, oeh}, 16'h0);
    latch(1'b1, 8'h00, 1'b1);
    wr(8'h77, s1, wd, s2);
    chk("R2 disabled command write no strobe", {10'h0, s1}, 16'h0);
    chk("R2 disabled command write ignored", {8'h0, cmd_o}, 16'h00A5);

    latch(1'b0, 8'h03, 1'b0);
    rd(d, oe, s1, s2, dh, oeh);
    chk("R1 captured memory select kept", {8'h0, d}, {8'h0, 8'h03 ^ 8'h5C});
    chk("R1 no port C strobe", {10'h0, s1}, 16'h0);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R6 reset clears command", {8'h0, cmd_o}, 16'h0);
    rd_n = 1'b0;
    @(negedge clk);
    chk("R6 R7 no drive after reset", {15'h0, ad_oe}, 16'h0);
    rd_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule